// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block keeps a small history of why the chip was last reset. Five upstream reset sources each send a one-cycle pulse: software request, watchdog expiry, brown-out, power-on and the external reset pin. Each pulse sets its own flag in a status word. Flags from software, watchdog and brown-out events pile up on top of whatever was already recorded. A power-on or pin event first throws away the software, watchdog and brown-out history, then records itself.

Software reads and rewrites the flags through a plain single-cycle register port. The port has an address, a write strobe, write data and read data. Writing zeros wipes the history. The flag storage ignores the system reset, so a record made while reset is held is still there afterwards. It starts at all-zero before any event.

Top module: `rst_cause_log`

## Requirements
- R1: The flags sit in the low bits of the status word: bit 0 external pin, bit 1 power-on, bit 2 brown-out, bit 3 watchdog, bit 4 software.
- R2: Bits 31 down to 5 always read as zero, and writing ones to them changes nothing.
- R3: A software, watchdog or brown-out pulse sets its flag and leaves every flag that was already set unchanged.
- R4: A power-on or pin pulse clears bits 4 to 2, keeps bits 1 and 0, and sets its own flag.
- R5: A write to the cause address loads write data bits 4 to 0 into the flags, so writing zero clears them.
- R6: When any event pulse and a write arrive in the same cycle, the write is dropped and the event rule applies.
- R7: With several pulses in one cycle, the power-on/pin clearing is applied first and then every pulsed flag is set.
- R8: The system reset neither clears nor loads the flags. Events are recorded while reset is held, and the flags are zero before the first event.
- R9: Read data is valid one cycle after the address, and is zero while reset is held. Any address other than the cause address reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; clears only the read data register |
| ev_sw | input | 1 | Software reset event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_bor | input | 1 | Brown-out reset event pulse |
| ev_por | input | 1 | Power-on reset event pulse |
| ev_pin | input | 1 | External pin reset event pulse |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the address |

## Verification
The bench records a watchdog event while reset is held and then reads it back. A design that resets its storage would return zero there. It then drives a power-on pulse over a full set of flags; a design that forgets the clearing rule keeps bits 4 to 2, and one that clears too much loses the pin flag. Same-cycle event and write pairs, and mixed pulses such as software with power-on, catch a design that lets the write win or that clears after setting instead of before. Writes of all ones and accesses to other addresses catch upper bits that leak and a decoder that is too loose.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
    localparam int NUM_CAUSES = 5;

    // Bit 4 down to bit 0 in declaration order (R1)
    typedef struct packed {
        logic sw;
        logic wdt;
        logic bor;
        logic por;
        logic pin;
    } cause_t;

    localparam cause_t KEEP_ON_HARD = '{sw: 1'b0, wdt: 1'b0, bor: 1'b0, por: 1'b1, pin: 1'b1};

    function automatic logic is_hard(input cause_t ev);
        return ev.por | ev.pin;
    endfunction

    // Clearing first, then setting all pulsed flags
    function automatic cause_t apply_events(input cause_t cur, input cause_t ev);
        cause_t base;
        base = is_hard(ev) ? (cur & KEEP_ON_HARD) : cur;
        return base | ev;
    endfunction
endpackage

// File: rtl/rcl_capture.sv
module rcl_capture
    import rcl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t ev,
    input  logic   wr_hit,
    input  cause_t wr_val,
    output cause_t flags
);
    // Storage is deliberately outside the system reset domain (R8)
    cause_t store = '0;

    always_ff @(posedge clk) begin
        if (|ev)
            store <= apply_events(store, ev);
        else if (wr_hit)
            store <= wr_val;
    end

    assign flags = store;

    // R3
    sticky_soft_chk: assert property (@(posedge clk) disable iff (rst)
        ((|ev) && !is_hard(ev)) |=> ((flags & $past(flags)) == $past(flags)));

    // R4
    hard_clear_chk: assert property (@(posedge clk) disable iff (rst)
        is_hard(ev) |=> ({flags.sw, flags.wdt, flags.bor} == $past({ev.sw, ev.wdt, ev.bor})));

    // R7
    pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((flags & $past(ev)) == $past(ev)));

    // R5
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !(|ev)) |=> (flags == $past(wr_val)));

    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && (|ev) && !is_hard(ev)) |=> ((flags & $past(flags)) == $past(flags)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|ev) && !wr_hit) |=> $stable(flags));
endmodule

// File: rtl/rcl_regport.sv
module rcl_regport
    import rcl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  cause_t            flags,
    output logic              wr_hit,
    output cause_t            wr_val,
    output logic [DATA_W-1:0] rdata
);
    logic              sel;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rd_q;

    assign sel    = (addr == CAUSE_ADDR);
    assign wr_hit = sel && we;
    assign wr_val = cause_t'(wdata[NUM_CAUSES-1:0]);

    // Zero-extend the flags to the data width (R2)
    for (genvar b = 0; b < DATA_W; b++) begin : g_word
        if (b < NUM_CAUSES) begin : g_flag
            assign word[b] = flags[b];
        end else begin : g_zero
            assign word[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= sel ? word : '0;
    end

    assign rdata = rd_q;

    // R9
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rdata == $past(sel ? {{(DATA_W-NUM_CAUSES){1'b0}}, flags} : '0)));
endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
    import rcl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sw,
    input  logic              ev_wdt,
    input  logic              ev_bor,
    input  logic              ev_por,
    input  logic              ev_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    cause_t ev;
    cause_t flags;
    cause_t wr_val;
    logic   wr_hit;

    assign ev = '{sw: ev_sw, wdt: ev_wdt, bor: ev_bor, por: ev_por, pin: ev_pin};

    rcl_regport #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CAUSE_ADDR (CAUSE_ADDR)
    ) u_port (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .flags  (flags),
        .wr_hit (wr_hit),
        .wr_val (wr_val),
        .rdata  (bus_rdata)
    );

    rcl_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .wr_hit (wr_hit),
        .wr_val (wr_val),
        .flags  (flags)
    );
endmodule

// File: tb/rst_cause_log_test.sv
`timescale 1ns/1ps
module rst_cause_log_test;
    localparam logic [7:0] CA = 8'h10;
    localparam logic [7:0] OTHER = 8'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_sw = 0, ev_wdt = 0, ev_bor = 0, ev_por = 0, ev_pin = 0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    bit [4:0] model = 5'b0;    // {sw,wdt,bor,por,pin}
    bit [31:0] exp_rd;
    bit done = 0;

    always #5 clk = ~clk;

    rst_cause_log uut (
        .clk(clk), .rst(rst),
        .ev_sw(ev_sw), .ev_wdt(ev_wdt), .ev_bor(ev_bor), .ev_por(ev_por), .ev_pin(ev_pin),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // One cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input bit [4:0] ev, input bit [7:0] a, input bit we,
                        input bit [31:0] wd, input string tag);
        {ev_sw, ev_wdt, ev_bor, ev_por, ev_pin} = ev;
        bus_addr = a; bus_we = we; bus_wdata = wd;
        @(posedge clk);
        exp_rd = (rst || a != CA) ? 32'h0 : {27'h0, model};
        if (ev != 0) begin
            if (ev[1] || ev[0]) model = model & 5'b00011;
            model = model | ev;
        end else if (we && a == CA) begin
            model = wd[4:0];
        end
        @(negedge clk);
        {ev_sw, ev_wdt, ev_bor, ev_por, ev_pin} = 5'b0;
        bus_we = 0;
        tests++;
        if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h", tag, bus_rdata, exp_rd);
        end
    endtask

    task automatic rd(input string tag);
        step(5'b0, CA, 0, 0, tag);
        step(5'b0, CA, 0, 0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(5'b0, CA, 0, 0, "R9 reset read");
        step(5'b01000, CA, 0, 0, "R8 event in reset");
        step(5'b0, CA, 0, 0, "R8");
        rst = 0;
        rd("R8 record survives reset");
        step(5'b0, CA, 1, 32'h0, "R5 clear");
        rd("R5");
        step(5'b10000, CA, 0, 0, "R1 sw");
        rd("R1 sw bit4");
        step(5'b0, CA, 1, 32'h0, "R5");
        step(5'b00100, CA, 0, 0, "R1 bor");
        rd("R1 bor bit2");
        step(5'b01000, CA, 0, 0, "R3 wdt");
        step(5'b10000, CA, 0, 0, "R3 sw");
        rd("R3 sticky");
        step(5'b00010, CA, 0, 0, "R4 por");
        rd("R4 por clears");
        step(5'b00001, CA, 0, 0, "R4 pin");
        rd("R4 pin keeps por");
        step(5'b10000, CA, 0, 0, "R3");
        rd("R3 on top of hard");
        step(5'b0, CA, 1, 32'hFFFF_FFFF, "R2 write ones");
        rd("R2 upper zero");
        step(5'b0, OTHER, 1, 32'h0, "R9 other write");
        step(5'b0, OTHER, 0, 0, "R9 other read zero");
        rd("R9 other write ignored");
        step(5'b0, CA, 1, 32'h0, "R5");
        step(5'b00100, CA, 1, 32'h1F, "R6 event beats write");
        rd("R6");
        step(5'b0, CA, 1, 32'h1F, "R5 all");
        step(5'b10010, CA, 0, 0, "R7 sw+por");
        rd("R7 clear then set");
        step(5'b01001, CA, 1, 32'h0, "R7 wdt+pin with write");
        rd("R7");
        rst = 1;
        step(5'b0, CA, 1, 32'h0, "R8 write in reset");
        step(5'b0, CA, 0, 0, "R8");
        rst = 0;
        step(5'b0, CA, 0, 0, "R8");
        rd("R8 reset keeps flags");
        for (int i = 0; i < 300; i++) begin
            bit [31:0] r;
            r = $urandom;
            step((r[3:0] == 0) ? r[8:4] : 5'b0, r[9] ? CA : OTHER, r[10], $urandom, "R7 mixed");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule